// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple host port and one single-data-rate SDRAM device with four banks and a 32-bit data bus. The host raises a request with an address, a write flag, write data and byte enables, and holds it until the block pulses an acknowledge. For every request the block opens the addressed row, issues one column read or write, and closes the bank again (closed-page policy). A read returns its word on `rdata` together with the acknowledge.

After reset the block brings the device up by itself. It waits a power-up delay, closes all banks, runs two auto refreshes and programs the mode register with the burst length and CAS latency parameters. Only then does it accept requests. A free-running interval timer then asks for an auto refresh at the rate that spreads 4096 refreshes over the refresh window. When a refresh is due, it takes precedence over any waiting request as soon as the current access has closed its bank.

Every device timing is a parameter in nanoseconds. It becomes a clock count by dividing by the clock period and rounding up. The refresh interval is the one exception: it is rounded down so that refreshes are never late. Every wait is at least two cycles.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: After reset release the command outputs show only NOP for the power-up delay. The block then issues precharge with address bit 10 high, two auto refreshes, and a mode register set. The mode word carries the burst-length code in address bits 2..0 (1→0, 2→1, 4→2, 8→3, full page→7) and the CAS latency in bits 6..4, with bank address 0.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n}: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. No other code appears, and all outputs rest at NOP, with no data drive and no acknowledge, during reset.
- R3: Mode register set and auto refresh are issued only while every bank is precharged. The cycle after a mode register set is a NOP.
- R4: Host address bits [22:21] go unchanged to the bank pins (bit 22 to BA1), bits [20:9] are the row sent with activate, and bits [8:0] are the column sent with read or write, with address bit 10 low.
- R5: A read or write follows its activate by exactly ceil(tRCD/tCK) cycles.
- R6: A write drives the host data with output enable in the same cycle, with mask lines equal to the inverted byte enables. The mask lines are all high in each following cycle up to and including the precharge. The single-bank precharge (bit 10 low) comes exactly max(tRDL, ceil(tRAS/tCK) − ceil(tRCD/tCK)) cycles after the write, with tRDL = 2.
- R7: During a read the mask lines stay low. The data word is captured at the edge CAS-latency cycles after the device samples the read command, and it is returned on `rdata` when `ack` pulses. The read is followed by precharge after max(2, ceil(tRAS/tCK) − ceil(tRCD/tCK)) cycles.
- R8: Auto refresh recurs every floor(window/4096/tCK) cycles while idle. A due refresh is issued before any pending host request, once the running access has precharged.
- R9: An activate goes only to a precharged bank, and at least ceil(tRP/tCK) cycles after the last precharge and ceil(tRC/tCK) cycles after the last refresh. `ack` is a one-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the device |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank, row, column} word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables, one per byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Last word read |
| sd_cs_n | output | 1 | Command bit 3 (chip select) |
| sd_ras_n | output | 1 | Command bit 2 |
| sd_cas_n | output | 1 | Command bit 1 |
| sd_we_n | output | 1 | Command bit 0 |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row, column or mode word |
| sd_dqm | output | 4 | Byte mask lines |
| sd_dq_out | output | 32 | Data driven to the device |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 32 | Data returned by the device |

## Verification
The hardest case to reach from the ports is a refresh that comes due while host traffic is arriving back to back. In that case the refresh must cut in between two accesses, never inside one, and never let a waiting request go first. The bench streams requests with no idle gap across several refresh intervals, checks that every refresh lands with all banks closed and within one access of its due time, and then idles to confirm the exact interval. A device model in the bench returns data only in the single cycle the CAS latency selects, so any wrong capture edge reads a garbage word.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT, ST_PREALL, ST_REF, ST_MRS, ST_IDLE,
    ST_ACT, ST_COL, ST_PRE, ST_DONE
  } st_e;

  function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned tck);
    return (ns + tck - 1) / tck;
  endfunction

  function automatic int unsigned at_least2(int unsigned v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned sat_sub(int unsigned a, int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

  function automatic int unsigned bl_code(int unsigned bl);
    case (bl)
      1:       return 0;
      2:       return 1;
      4:       return 2;
      8:       return 3;
      default: return 7;
    endcase
  endfunction

  // burst code in bits 2..0, sequential order (bit 3 = 0), latency in bits 6..4
  function automatic int unsigned mode_word(int unsigned cl, int unsigned bl);
    return (cl << 4) | bl_code(bl);
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic due
);
  localparam int unsigned CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;
  logic          expire;

  assign expire = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due   <= 1'b0;
    end else begin
      cnt_q <= expire ? '0 : cnt_q + 1'b1;
      if (expire)   due <= 1'b1;
      else if (clr) due <= 1'b0;
    end
  end

  // R8: a pending refresh request is only withdrawn by issuing the refresh
  p_due_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !clr) |=> due);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int unsigned CL = 2,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_cmd,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] data_q,
  output logic          valid_q
);
  logic [CL-1:0] pipe_q;

  generate
    if (CL == 1) begin : g_cl1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= rd_cmd;
    end else begin : g_cln
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[CL-2:0], rd_cmd};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= pipe_q[CL-1];
      if (pipe_q[CL-1]) data_q <= dq_in;
    end
  end

  // R7: reads are spaced so that at most one word is in flight
  p_one_inflight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pipe_q));

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned POWERUP_NS    = 200000,
  parameter int unsigned T_RCD_NS      = 19,
  parameter int unsigned T_RP_NS       = 19,
  parameter int unsigned T_RAS_NS      = 50,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_RDL_CLK     = 2,
  parameter int unsigned T_REFW_NS     = 64000000,
  parameter int unsigned REF_ROWS      = 4096,
  parameter int unsigned CAS_LAT       = 2,
  parameter int unsigned BURST_LEN     = 1,
  parameter int unsigned BA_W          = 2,
  parameter int unsigned ROW_W         = 12,
  parameter int unsigned COL_W         = 9,
  parameter int unsigned DQ_W          = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req,
  input  logic                          req_we,
  input  logic [BA_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]               req_wdata,
  input  logic [DQ_W/8-1:0]             req_be,
  output logic                          ack,
  output logic [DQ_W-1:0]               rdata,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BA_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DQ_W/8-1:0]             sd_dqm,
  output logic [DQ_W-1:0]               sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DQ_W-1:0]               sd_dq_in
);
  localparam int unsigned BE_W    = DQ_W / 8;
  localparam int unsigned NBANK   = 1 << BA_W;
  localparam int unsigned HA_W    = BA_W + ROW_W + COL_W;
  localparam int unsigned TRCD_C  = at_least2(ns_to_clk(T_RCD_NS, CLK_PERIOD_NS));
  localparam int unsigned TRP_C   = at_least2(ns_to_clk(T_RP_NS, CLK_PERIOD_NS));
  localparam int unsigned TRAS_C  = ns_to_clk(T_RAS_NS, CLK_PERIOD_NS);
  localparam int unsigned TRC_C   = at_least2(ns_to_clk(T_RC_NS, CLK_PERIOD_NS));
  localparam int unsigned PWR_C   = at_least2(ns_to_clk(POWERUP_NS, CLK_PERIOD_NS));
  localparam int unsigned TRDL_C  = at_least2(T_RDL_CLK);
  localparam int unsigned TMRD_C  = 2;
  localparam int unsigned WR2PRE  = at_least2(max_u(TRDL_C, sat_sub(TRAS_C, TRCD_C)));
  localparam int unsigned RD2PRE  = at_least2(sat_sub(TRAS_C, TRCD_C));
  localparam int unsigned REFI_C  = T_REFW_NS / REF_ROWS / CLK_PERIOD_NS;
  localparam int unsigned WAIT_MX = max_u(max_u(PWR_C, TRC_C), max_u(WR2PRE, RD2PRE));
  localparam int unsigned WC_W    = $clog2(WAIT_MX + 1);
  localparam int unsigned SC_W    = 8;
  localparam logic [ROW_W-1:0] MODE_VAL = ROW_W'(mode_word(CAS_LAT, BURST_LEN));
  localparam logic [ROW_W-1:0] A10_ALL  = ROW_W'(1) << 10;

  st_e               st_q, ret_q;
  logic [WC_W-1:0]   wait_q;
  logic [1:0]        init_refs_q;
  cmd_e              cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BE_W-1:0]   dqm_q;
  logic [DQ_W-1:0]   dq_out_q;
  logic              dq_oe_q, ack_q, wr_tail_q;
  logic              h_we;
  logic [BA_W-1:0]   h_ba;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic [DQ_W-1:0]   h_wdata;
  logic [BE_W-1:0]   h_be;

  // named internal events
  logic ev_ref_issue, ref_due, ev_rd_out, cap_valid;
  assign ev_ref_issue = (st_q == ST_REF);
  assign ev_rd_out    = (cmd_q == CMD_RD);

  sdram_refresh_timer #(.PERIOD(REFI_C)) u_refi (
    .clk(clk), .rst_n(rst_n), .clr(ev_ref_issue), .due(ref_due));

  sdram_rd_capture #(.CL(CAS_LAT), .DW(DQ_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_cmd(ev_rd_out), .dq_in(sd_dq_in),
    .data_q(rdata), .valid_q(cap_valid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_WAIT;
      ret_q       <= ST_PREALL;
      wait_q      <= WC_W'(PWR_C - 2);
      init_refs_q <= 2'd0;
      cmd_q       <= CMD_NOP;
      ba_q        <= '0;
      addr_q      <= '0;
      dqm_q       <= '0;
      dq_out_q    <= '0;
      dq_oe_q     <= 1'b0;
      ack_q       <= 1'b0;
      wr_tail_q   <= 1'b0;
      h_we        <= 1'b0;
      h_ba        <= '0;
      h_row       <= '0;
      h_col       <= '0;
      h_wdata     <= '0;
      h_be        <= '0;
    end else begin
      cmd_q   <= CMD_NOP;
      ack_q   <= 1'b0;
      dq_oe_q <= 1'b0;
      unique case (st_q)
        ST_WAIT: begin
          dqm_q <= wr_tail_q ? '1 : '0;
          if (wait_q == '0) st_q <= ret_q;
          else              wait_q <= wait_q - 1'b1;
        end
        ST_PREALL: begin
          cmd_q       <= CMD_PRE;
          addr_q      <= A10_ALL;
          init_refs_q <= 2'd2;
          wait_q      <= WC_W'(TRP_C - 2);
          ret_q       <= ST_REF;
          st_q        <= ST_WAIT;
        end
        ST_REF: begin
          cmd_q  <= CMD_REF;
          wait_q <= WC_W'(TRC_C - 2);
          st_q   <= ST_WAIT;
          if (init_refs_q != 2'd0) init_refs_q <= init_refs_q - 2'd1;
          ret_q <= (init_refs_q == 2'd2) ? ST_REF :
                   (init_refs_q == 2'd1) ? ST_MRS : ST_IDLE;
        end
        ST_MRS: begin
          cmd_q  <= CMD_MRS;
          ba_q   <= '0;
          addr_q <= MODE_VAL;
          wait_q <= WC_W'(TMRD_C - 2);
          ret_q  <= ST_IDLE;
          st_q   <= ST_WAIT;
        end
        ST_IDLE: begin
          dqm_q <= '0;
          if (ref_due) begin
            st_q <= ST_REF;
          end else if (req) begin
            h_we    <= req_we;
            h_ba    <= req_addr[HA_W-1 -: BA_W];
            h_row   <= req_addr[COL_W +: ROW_W];
            h_col   <= req_addr[0 +: COL_W];
            h_wdata <= req_wdata;
            h_be    <= req_be;
            st_q    <= ST_ACT;
          end
        end
        ST_ACT: begin
          cmd_q  <= CMD_ACT;
          ba_q   <= h_ba;
          addr_q <= h_row;
          wait_q <= WC_W'(TRCD_C - 2);
          ret_q  <= ST_COL;
          st_q   <= ST_WAIT;
        end
        ST_COL: begin
          addr_q <= ROW_W'(h_col);
          ret_q  <= ST_PRE;
          st_q   <= ST_WAIT;
          if (h_we) begin
            cmd_q     <= CMD_WR;
            dq_out_q  <= h_wdata;
            dq_oe_q   <= 1'b1;
            dqm_q     <= ~h_be;
            wr_tail_q <= 1'b1;
            wait_q    <= WC_W'(WR2PRE - 2);
          end else begin
            cmd_q  <= CMD_RD;
            dqm_q  <= '0;
            wait_q <= WC_W'(RD2PRE - 2);
          end
        end
        ST_PRE: begin
          cmd_q     <= CMD_PRE;
          addr_q    <= '0;
          dqm_q     <= wr_tail_q ? '1 : '0;
          wr_tail_q <= 1'b0;
          wait_q    <= WC_W'(TRP_C - 2);
          ret_q     <= ST_DONE;
          st_q      <= ST_WAIT;
        end
        ST_DONE: begin
          ack_q <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dq_out_q;
  assign sd_dq_oe  = dq_oe_q;
  assign ack       = ack_q;

  // bank state and spacing counters observed from the command stream
  logic [NBANK-1:0] open_q;
  logic [SC_W-1:0]  since_act, since_wr, since_pre, since_ref;

  function automatic logic [SC_W-1:0] bump(logic [SC_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= '0;
      since_act <= '1;
      since_wr  <= '1;
      since_pre <= '1;
      since_ref <= '1;
    end else begin
      since_act <= (cmd_q == CMD_ACT) ? SC_W'(1) : bump(since_act);
      since_wr  <= (cmd_q == CMD_WR)  ? SC_W'(1) : bump(since_wr);
      since_pre <= (cmd_q == CMD_PRE) ? SC_W'(1) : bump(since_pre);
      since_ref <= (cmd_q == CMD_REF) ? SC_W'(1) : bump(since_ref);
      if (cmd_q == CMD_ACT) open_q[ba_q] <= 1'b1;
      if (cmd_q == CMD_PRE) begin
        if (addr_q[10]) open_q <= '0;
        else            open_q[ba_q] <= 1'b0;
      end
    end
  end

  p_mrs_banks_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |-> (open_q == '0));
  p_ref_banks_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> (open_q == '0));
  p_mrs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
  p_rcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_act >= SC_W'(TRCD_C)));
  p_wr_to_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> (since_wr >= SC_W'(TRDL_C)));
  p_rd_mask_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cap_valid) |-> (dqm_q == '0));
  p_act_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT) |-> (!open_q[ba_q] && since_pre >= SC_W'(TRP_C)
                            && since_ref >= SC_W'(TRC_C)));
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

endmodule

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb;
  localparam int TCK   = 4;
  localparam int CL    = 2;
  localparam int PWR   = (400 + TCK - 1) / TCK;
  localparam int RCD   = (19 + TCK - 1) / TCK;
  localparam int RP    = (19 + TCK - 1) / TCK;
  localparam int RAS   = (50 + TCK - 1) / TCK;
  localparam int RC    = (70 + TCK - 1) / TCK;
  localparam int WPRE  = (RAS - RCD > 2) ? RAS - RCD : 2;
  localparam int RPRE  = (RAS - RCD > 2) ? RAS - RCD : 2;
  localparam int REFI  = (4096 * 4000) / 4096 / TCK;
  localparam logic [11:0] MODE = 12'(CL * 16);

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic ack;
  logic [31:0] rdata;
  logic cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [1:0] ba;
  logic [11:0] sa;
  logic [3:0] dqm;
  logic [31:0] dq_out;
  logic [31:0] dq_in = 32'hDEAD_BEEF;

  always #(TCK/2) clk = ~clk;

  sdram_cmd_ctrl #(
    .CLK_PERIOD_NS(TCK), .POWERUP_NS(400), .T_REFW_NS(4096 * 4000),
    .CAS_LAT(CL), .BURST_LEN(1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(sa), .sd_dqm(dqm), .sd_dq_out(dq_out),
    .sd_dq_oe(dq_oe), .sd_dq_in(dq_in));

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // device model and command monitor
  logic [31:0] mem [int];
  logic [31:0] host_mem [int];
  bit [3:0] bopen = '0;
  logic [11:0] orow [4];
  int cyc = 0, init_idx = 0;
  int t_act = -1000, t_col = -1000, t_pre = -1000, t_ref = -1000, t_mrs = -1000;
  int rd_due = -1;
  logic [31:0] rd_word = '0;
  bit wr_tail = 0;
  int nref_run = 0, prev_ref = -1, last_gap = 0, prev_gap = 0;
  logic [8:0] last_col = '0;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    if (!rst_n) begin
      cyc = 0;
      chk(c == 4'b0111 && !dq_oe && !ack, "R2 reset outputs", {c, 3'b0, dq_oe, 3'b0, ack}, 64'h700);
    end else begin
      cyc++;
      dq_in = (cyc == rd_due) ? rd_word : 32'hDEAD_BEEF;
      if (cyc == t_mrs + 1) chk(c == 4'b0111, "R3 NOP after mode set", c, 4'b0111);
      if (c == 4'b0111) begin
        if (wr_tail) chk(dqm == 4'hF, "R6 tail mask", dqm, 4'hF);
      end else begin
        chk(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101},
            "R2 legal code", c, 4'b0111);
        if (init_idx < 4) begin
          case (init_idx)
            0: begin
              chk(c == 4'b0010 && sa[10], "R1 first precharge-all", {c, 4'b0, sa}, {4'b0010, 4'b0, 12'h400});
              chk(cyc >= PWR && cyc <= PWR + 2, "R1 power-up delay", cyc, PWR);
            end
            1, 2: chk(c == 4'b0001, "R1 init refresh", c, 4'b0001);
            default: begin
              chk(c == 4'b0000, "R1 mode set", c, 4'b0000);
              chk(sa == MODE && ba == 2'b00, "R1 mode word", {ba, sa}, {2'b00, MODE});
            end
          endcase
          init_idx++;
        end
        case (c)
          4'b0000: begin chk(bopen == 0, "R3 mode set banks idle", bopen, 0); t_mrs = cyc; end
          4'b0001: begin
            chk(bopen == 0, "R3 refresh banks idle", bopen, 0);
            if (init_idx >= 4) begin
              nref_run++;
              if (prev_ref >= 0) begin
                prev_gap = last_gap;
                last_gap = cyc - prev_ref;
                chk(last_gap >= REFI - 40 && last_gap <= REFI + 40, "R8 refresh interval", last_gap, REFI);
              end else begin
                chk(cyc <= REFI + 45, "R8 first refresh", cyc, REFI);
              end
              prev_ref = cyc;
            end
            t_ref = cyc;
          end
          4'b0011: begin
            chk(!bopen[ba], "R9 activate closed bank", bopen, 0);
            chk(cyc - t_pre >= RP && cyc - t_ref >= RC, "R9 activate spacing", cyc - t_pre, RP);
            chk(ba == req_addr[22:21] && sa == req_addr[20:9], "R4 bank/row mapping",
                {ba, sa}, {req_addr[22:21], req_addr[20:9]});
            bopen[ba] = 1; orow[ba] = sa; t_act = cyc;
          end
          4'b0100, 4'b0101: begin
            int key;
            chk(cyc - t_act == RCD, "R5 activate-to-column", cyc - t_act, RCD);
            chk(bopen[ba] && sa[8:0] == req_addr[8:0] && !sa[10], "R4 column mapping",
                {bopen[ba], sa}, {1'b1, 3'b0, req_addr[8:0]});
            key = int'({ba, orow[ba], sa[8:0]});
            if (c == 4'b0100) begin
              logic [31:0] w;
              chk(dqm == ~req_be, "R6 write mask", dqm, ~req_be);
              chk(dq_oe && dq_out == req_wdata, "R6 write data", dq_out, req_wdata);
              w = mem.exists(key) ? mem[key] : 32'h0;
              for (int j = 0; j < 4; j++) if (!dqm[j]) w[8*j +: 8] = dq_out[8*j +: 8];
              mem[key] = w;
              wr_tail = 1;
            end else begin
              chk(dqm == 4'h0, "R7 read mask low", dqm, 0);
              rd_word = mem.exists(key) ? mem[key] : 32'h0;
              rd_due = cyc + CL;
            end
            t_col = cyc;
          end
          4'b0010: begin
            if (init_idx > 1) begin
              chk(!sa[10], "R6 single-bank precharge", sa[10], 0);
              chk(cyc - t_col == (wr_tail ? WPRE : RPRE), "R6 column-to-precharge",
                  cyc - t_col, wr_tail ? WPRE : RPRE);
              if (wr_tail) chk(dqm == 4'hF, "R6 mask at precharge", dqm, 4'hF);
              bopen[ba] = 0;
            end else bopen = '0;
            wr_tail = 0;
            t_pre = cyc;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic xfer(bit we, logic [22:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    while (!ack) @(negedge clk);
    if (!we) begin
      logic [31:0] e;
      e = host_mem.exists(int'(a)) ? host_mem[int'(a)] : 32'h0;
      chk(rdata == e, "R7 read data", rdata, e);
    end else begin
      logic [31:0] e;
      e = host_mem.exists(int'(a)) ? host_mem[int'(a)] : 32'h0;
      for (int j = 0; j < 4; j++) if (be[j]) e[8*j +: 8] = d[8*j +: 8];
      host_mem[int'(a)] = e;
    end
    req = 0;
    @(negedge clk);
    chk(!ack, "R9 ack single pulse", ack, 0);
  endtask

  function automatic logic [22:0] mk_addr(int b, int i);
    return {2'(b), 12'(i * 37 + b * 1000 + 1), 9'(i * 101 + b * 7)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1 rst_n = 1;
    wait (init_idx == 4);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 4; i++)
        xfer(1, mk_addr(b, i), 32'h1000_0000 * (b + 1) + 32'h0101 * (i + 3), 4'hF);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 4; i++)
        xfer(1, mk_addr(b, i), 32'hA5C3_0000 ^ (32'h77 * (b * 4 + i)), 4'((b * 4 + i) % 16));
    for (int r = 0; r < 3; r++)
      for (int b = 0; b < 4; b++)
        for (int i = 0; i < 4; i++)
          xfer(0, mk_addr(b, i), 32'h0, 4'hF);
    repeat (3 * REFI + 50) @(negedge clk);
    chk(nref_run >= 4, "R8 refresh count", nref_run, 4);
    chk(last_gap == REFI && prev_gap == REFI, "R8 idle interval exact", {last_gap, prev_gap}, {REFI, REFI});
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule